// File: doc/BRIEF.md
# Buffer Fill Threshold and DMA Request Gate

This block is a 32-entry, 16-bit circular data buffer placed between a host register port and a card-side data engine. The host writes and reads halfwords through single-cycle strobes. The card engine moves data through two valid/ready streams: one fills the buffer in the receive direction and one drains it in the transmit direction. The transfer direction and whether a transfer is running come in as plain control pins.

The buffer fill count is compared against two programmable levels held in a configuration register. In the receive direction the block watches for the count to rise above an almost-full level. In the transmit direction it watches for the count to fall below an almost-empty level. When the condition for the active direction holds, the block raises either that direction's DMA request or that direction's level flag. Which one it raises depends on a per-direction DMA enable, and it never raises both. The level flags sit at status positions 10 (receive) and 11 (transmit). The host clears them by writing ones to those bit positions of a clear mask. All four outputs are flops.

On the card streams, a beat moves when valid and ready are both high at a rising edge. The receive stream is ready only while a receive transfer is active, the buffer is not full, and the host is not writing in that cycle. The transmit stream is valid only while a transmit transfer is active, the buffer is not empty, and the host is not reading in that cycle. A host strobe in a cycle therefore holds off the card beat for that cycle.

Top module: `fifo_level_dma`

## Requirements
- R1: The buffer returns halfwords in the order they were pushed, from host writes or card receive beats, and its read and write indices wrap modulo 32. `host_rdata` and `card_out_data` always show the entry at the read index.
- R2: A host write while the buffer holds 32 entries is dropped: no entry, index or count changes, and the entry at the write index keeps its old value.
- R3: A host read while the buffer is empty returns the entry at the read index and does not pop it. A later read without an intervening write returns the same entry.
- R4: The configuration register holds the receive DMA enable at bit 15, the almost-full level at bits 12:8, the transmit DMA enable at bit 7 and the almost-empty level at bits 4:0. Other bits read as zero. After reset it reads 0x1F00, which is almost-full 31, almost-empty 0 and both enables off.
- R5: With direction receive (`xfer_dir`=1) and a count above the almost-full level, `rx_dma_req` is high if receive DMA is enabled. Otherwise `rx_lvl_flag` (status bit 10) is set.
- R6: With direction transmit (`xfer_dir`=0) and a count below the almost-empty level, `tx_dma_req` is high if transmit DMA is enabled. Otherwise `tx_lvl_flag` (status bit 11) is set.
- R7: When a direction's condition does not hold, its DMA request is low. When it is re-evaluated, its level flag is cleared.
- R8: When no transfer is active and the buffer is empty, both level flags and both DMA requests are low.
- R9: A configuration write that sets a DMA enable clears the matching level flag at the same edge.
- R10: Both flags are re-evaluated on every event: a push, a pop, a configuration write, or a change of `xfer_active` or `xfer_dir`. Between events a flag holds its value unless `flag_clr_we` is high with mask bit 10 (receive) or bit 11 (transmit) set, which clears it. If an event and a clear occur in the same cycle, the event's evaluation wins.
- R11: `card_in_ready` = transfer active, receive, not full and no host write. `card_out_valid` = transfer active, transmit, not empty and no host read.
- R12: Outputs reflect the state after the edge at which a strobe or beat is applied: fill count, configuration and direction pins are all taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register read value |
| host_wr | input | 1 | Host data-port write (push) strobe |
| host_wdata | input | 16 | Host push data |
| host_rd | input | 1 | Host data-port read (pop) strobe |
| host_rdata | output | 16 | Entry at the read index |
| flag_clr_we | input | 1 | Level-flag clear strobe |
| flag_clr_mask | input | 16 | Write-one-to-clear mask, bit 10 receive, bit 11 transmit |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = receive (card fills), 0 = transmit (card drains) |
| card_in_valid | input | 1 | Card receive beat valid |
| card_in_ready | output | 1 | Buffer accepts a card receive beat |
| card_in_data | input | 16 | Card receive halfword |
| card_out_valid | output | 1 | Halfword available for the card |
| card_out_ready | input | 1 | Card accepts the transmit halfword |
| card_out_data | output | 16 | Transmit halfword at the read index |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_lvl_flag | output | 1 | Receive level flag (status bit 10) |
| tx_lvl_flag | output | 1 | Transmit level flag (status bit 11) |

## Verification
The properties assume that every input is at a known level from the first edge after reset and that strobes are sampled only at rising edges. They also assume the card side respects the handshake: a beat counts only when valid and ready meet, so the count can never leave 0..32. The stimulus changes every input at the falling edge and holds it steady through the next rising edge. It holds all strobes low while reset is asserted. It drives the card streams only in the direction the direction pin selects, so overlapping host and card accesses happen only where the back-pressure rule decides them.

// File: rtl/fld_pkg.sv
package fld_pkg;

  // Register word width of the host port.
  localparam int unsigned REG_W = 16;

  // Configuration register field positions (decoded by software).
  localparam int unsigned RX_EN_BIT = 15;
  localparam int unsigned AF_LSB    = 8;
  localparam int unsigned TX_EN_BIT = 7;
  localparam int unsigned AE_LSB    = 0;

  // Status positions of the level flags (decoded by the status neighbour).
  localparam int unsigned STAT_RX_BIT = 10;
  localparam int unsigned STAT_TX_BIT = 11;

  // Registered outputs of the threshold evaluator.
  typedef struct packed {
    logic rx_req;
    logic tx_req;
    logic rx_flag;
    logic tx_flag;
  } lvl_out_t;

endpackage

// File: rtl/fld_cfg_reg.sv
module fld_cfg_reg
  import fld_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  // next-state view, so the evaluator sees a write at the same edge
  output logic             rx_en_d,
  output logic             tx_en_d,
  output logic [LVL_W-1:0] af_d,
  output logic [LVL_W-1:0] ae_d
);

  localparam logic [LVL_W-1:0] AF_RST = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] AE_RST = '0;

  logic             rx_en_q, tx_en_q;
  logic [LVL_W-1:0] af_q, ae_q;

  always_comb begin
    if (we) begin
      rx_en_d = wdata[RX_EN_BIT];
      tx_en_d = wdata[TX_EN_BIT];
      af_d    = wdata[AF_LSB +: LVL_W];
      ae_d    = wdata[AE_LSB +: LVL_W];
    end else begin
      rx_en_d = rx_en_q;
      tx_en_d = tx_en_q;
      af_d    = af_q;
      ae_d    = ae_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      af_q    <= AF_RST;
      ae_q    <= AE_RST;
    end else begin
      rx_en_q <= rx_en_d;
      tx_en_q <= tx_en_d;
      af_q    <= af_d;
      ae_q    <= ae_d;
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[RX_EN_BIT]          = rx_en_q;
    rdata[TX_EN_BIT]          = tx_en_q;
    rdata[AF_LSB +: LVL_W]    = af_q;
    rdata[AE_LSB +: LVL_W]    = ae_q;
  end

  // Bits of the write word that carry no field.
  logic unused_wbits;
  assign unused_wbits = ^{wdata[14:13], wdata[6:5]};

endmodule

// File: rtl/fld_store.sv
module fld_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W:0]    count_q,
  output logic [LVL_W:0]    count_d,
  output logic              full,
  output logic              empty,
  output logic              push_ok,
  output logic              pop_ok
);

  localparam int unsigned DEPTH = 1 << LVL_W;
  localparam int unsigned CNT_W = LVL_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  wr_idx, rd_idx;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  // Indices are LVL_W wide, so they wrap modulo DEPTH on their own.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      rd_idx  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_idx <= wr_idx + 1'b1;
      if (pop_ok)  rd_idx <= rd_idx + 1'b1;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_data;
  end

  assign head_data = mem[rd_idx];

endmodule

// File: rtl/fld_lvl_eval.sv
module fld_lvl_eval
  import fld_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W:0]   count_d,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic [LVL_W-1:0] af_lvl,
  input  logic [LVL_W-1:0] ae_lvl,
  input  logic             xfer_active,
  input  logic             xfer_dir,
  input  logic             evt,
  input  logic             clr_rx,
  input  logic             clr_tx,
  output lvl_out_t         lvl_q
);

  logic idle_empty, rx_hit, tx_hit;
  lvl_out_t lvl_d;

  assign idle_empty = ~xfer_active & (count_d == '0);
  assign rx_hit     = ~idle_empty &  xfer_dir & (count_d > {1'b0, af_lvl});
  assign tx_hit     = ~idle_empty & ~xfer_dir & (count_d < {1'b0, ae_lvl});

  always_comb begin
    lvl_d        = lvl_q;
    // Requests follow their condition every cycle.
    lvl_d.rx_req = rx_hit & rx_en;
    lvl_d.tx_req = tx_hit & tx_en;
    // Flags are re-evaluated on events; otherwise the clear mask acts.
    if (evt) begin
      lvl_d.rx_flag = rx_hit & ~rx_en;
      lvl_d.tx_flag = tx_hit & ~tx_en;
    end else begin
      if (clr_rx) lvl_d.rx_flag = 1'b0;
      if (clr_tx) lvl_d.tx_flag = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

endmodule

// File: rtl/fifo_level_dma.sv
module fifo_level_dma
  import fld_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              flag_clr_we,
  input  logic [15:0]       flag_clr_mask,
  input  logic              xfer_active,
  input  logic              xfer_dir,
  input  logic              card_in_valid,
  output logic              card_in_ready,
  input  logic [DATA_W-1:0] card_in_data,
  output logic              card_out_valid,
  input  logic              card_out_ready,
  output logic [DATA_W-1:0] card_out_data,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              rx_lvl_flag,
  output logic              tx_lvl_flag
);

  logic             rx_en_d, tx_en_d;
  logic [LVL_W-1:0] af_d, ae_d;
  logic [LVL_W:0]   count_q, count_d;
  logic             full, empty, push_ok, pop_ok;
  logic             in_fire, out_fire, push, pop;
  logic [DATA_W-1:0] push_data, head_data;
  logic             xfer_q, dir_q, evt;
  logic             clr_rx, clr_tx;
  lvl_out_t         lvl_q;

  // Card streams: a host strobe in the same cycle takes precedence.
  assign card_in_ready  = xfer_active &  xfer_dir & ~full  & ~host_wr;
  assign card_out_valid = xfer_active & ~xfer_dir & ~empty & ~host_rd;
  assign in_fire        = card_in_valid & card_in_ready;
  assign out_fire       = card_out_valid & card_out_ready;

  assign push      = host_wr | in_fire;
  assign push_data = host_wr ? host_wdata : card_in_data;
  assign pop       = host_rd | out_fire;

  fld_cfg_reg #(.LVL_W(LVL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .rx_en_d (rx_en_d),
    .tx_en_d (tx_en_d),
    .af_d    (af_d),
    .ae_d    (ae_d)
  );

  fld_store #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .count_q   (count_q),
    .count_d   (count_d),
    .full      (full),
    .empty     (empty),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      xfer_q <= xfer_active;
      dir_q  <= xfer_dir;
    end
  end

  // Anything that can move a threshold condition re-evaluates the flags.
  assign evt = push_ok | pop_ok | cfg_we |
               (xfer_active != xfer_q) | (xfer_dir != dir_q);

  assign clr_rx = flag_clr_we & flag_clr_mask[STAT_RX_BIT];
  assign clr_tx = flag_clr_we & flag_clr_mask[STAT_TX_BIT];

  fld_lvl_eval #(.LVL_W(LVL_W)) u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_d     (count_d),
    .rx_en       (rx_en_d),
    .tx_en       (tx_en_d),
    .af_lvl      (af_d),
    .ae_lvl      (ae_d),
    .xfer_active (xfer_active),
    .xfer_dir    (xfer_dir),
    .evt         (evt),
    .clr_rx      (clr_rx),
    .clr_tx      (clr_tx),
    .lvl_q       (lvl_q)
  );

  assign rx_dma_req    = lvl_q.rx_req;
  assign tx_dma_req    = lvl_q.tx_req;
  assign rx_lvl_flag   = lvl_q.rx_flag;
  assign tx_lvl_flag   = lvl_q.tx_flag;
  assign host_rdata    = head_data;
  assign card_out_data = head_data;

  logic unused_mask;
  assign unused_mask = ^{flag_clr_mask[15:12], flag_clr_mask[9:0]};

endmodule

// File: rtl/fld_chk.sv
module fld_chk
  import fld_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_wr,
  input logic           host_rd,
  input logic           cfg_we,
  input logic [15:0]    cfg_wdata,
  input logic           flag_clr_we,
  input logic [15:0]    flag_clr_mask,
  input logic           evt,
  input logic [LVL_W:0] count,
  input logic           xfer_q,
  input logic           in_fire,
  input logic           out_fire,
  input logic           card_out_valid,
  input logic           rx_dma_req,
  input logic           tx_dma_req,
  input logic           rx_lvl_flag,
  input logic           tx_lvl_flag
);

  localparam logic [LVL_W:0] FULL_CNT = (LVL_W + 1)'(1 << LVL_W);

  // R1: the count stays within the buffer size
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R1: a transmit beat is offered only with data present
  a_r1_out_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    card_out_valid |-> count != '0);

  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && count == FULL_CNT && !host_rd && !out_fire) |=> $stable(count));

  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && count == '0 && !host_wr && !in_fire) |=> count == '0);

  a_r5_rx_one_of: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_dma_req && rx_lvl_flag));

  a_r6_tx_one_of: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_dma_req && tx_lvl_flag));

  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_dma_req && tx_dma_req));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !xfer_q) |-> !(rx_dma_req || tx_dma_req || rx_lvl_flag || tx_lvl_flag));

  a_r9_rx_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[RX_EN_BIT]) |=> !rx_lvl_flag);

  a_r9_tx_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[TX_EN_BIT]) |=> !tx_lvl_flag);

  a_r10_clear_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_we && flag_clr_mask[STAT_RX_BIT] && !evt) |=> !rx_lvl_flag);

  a_r10_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !(flag_clr_we && flag_clr_mask[STAT_TX_BIT])) |=> $stable(tx_lvl_flag));

endmodule

bind fifo_level_dma fld_chk #(.LVL_W(LVL_W)) u_fld_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr        (host_wr),
  .host_rd        (host_rd),
  .cfg_we         (cfg_we),
  .cfg_wdata      (cfg_wdata),
  .flag_clr_we    (flag_clr_we),
  .flag_clr_mask  (flag_clr_mask),
  .evt            (evt),
  .count          (count_q),
  .xfer_q         (xfer_q),
  .in_fire        (in_fire),
  .out_fire       (out_fire),
  .card_out_valid (card_out_valid),
  .rx_dma_req     (rx_dma_req),
  .tx_dma_req     (tx_dma_req),
  .rx_lvl_flag    (rx_lvl_flag),
  .tx_lvl_flag    (tx_lvl_flag)
);

// File: tb/test_fifo_level_dma.sv
module test_fifo_level_dma;

  localparam int PERIOD = 10;

  localparam logic [2:0] OP_NOP = 3'd0, OP_CFG = 3'd1, OP_HWR = 3'd2, OP_HRD = 3'd3,
                         OP_CLR = 3'd4, OP_CPSH = 3'd5, OP_CPOP = 3'd6;

  // {op, arg, xfer, dir, {rx_req,tx_req,rx_flag,tx_flag}, expected data}
  localparam int NV = 22;
  localparam logic [40:0] VECS [NV] = '{
    {OP_CFG,  16'h0304, 1'b1, 1'b0, 4'b0001, 16'h0000},
    {OP_HWR,  16'hA001, 1'b1, 1'b0, 4'b0001, 16'h0000},
    {OP_HWR,  16'hA002, 1'b1, 1'b0, 4'b0001, 16'h0000},
    {OP_HWR,  16'hA003, 1'b1, 1'b0, 4'b0001, 16'h0000},
    {OP_CLR,  16'h0800, 1'b1, 1'b0, 4'b0000, 16'h0000},
    {OP_HWR,  16'hA004, 1'b1, 1'b0, 4'b0000, 16'h0000},
    {OP_CPOP, 16'h0000, 1'b1, 1'b0, 4'b0001, 16'hA001},
    {OP_CFG,  16'h0384, 1'b1, 1'b0, 4'b0100, 16'h0000},
    {OP_CPOP, 16'h0000, 1'b1, 1'b0, 4'b0100, 16'hA002},
    {OP_HRD,  16'h0000, 1'b1, 1'b0, 4'b0100, 16'hA003},
    {OP_HRD,  16'h0000, 1'b1, 1'b0, 4'b0100, 16'hA004},
    {OP_NOP,  16'h0000, 1'b0, 1'b0, 4'b0000, 16'h0000},
    {OP_CFG,  16'h8302, 1'b1, 1'b1, 4'b0000, 16'h0000},
    {OP_CPSH, 16'hB001, 1'b1, 1'b1, 4'b0000, 16'h0000},
    {OP_CPSH, 16'hB002, 1'b1, 1'b1, 4'b0000, 16'h0000},
    {OP_CPSH, 16'hB003, 1'b1, 1'b1, 4'b0000, 16'h0000},
    {OP_CPSH, 16'hB004, 1'b1, 1'b1, 4'b1000, 16'h0000},
    {OP_CFG,  16'h0302, 1'b1, 1'b1, 4'b0010, 16'h0000},
    {OP_HRD,  16'h0000, 1'b1, 1'b1, 4'b0000, 16'hB001},
    {OP_CPSH, 16'hB005, 1'b1, 1'b1, 4'b0010, 16'h0000},
    {OP_CLR,  16'h0400, 1'b1, 1'b1, 4'b0000, 16'h0000},
    {OP_HRD,  16'h0000, 1'b1, 1'b1, 4'b0000, 16'hB002}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic        flag_clr_we = 1'b0;
  logic [15:0] flag_clr_mask = '0;
  logic        xfer_active = 1'b0;
  logic        xfer_dir = 1'b0;
  logic        card_in_valid = 1'b0;
  logic        card_in_ready;
  logic [15:0] card_in_data = '0;
  logic        card_out_valid;
  logic        card_out_ready = 1'b0;
  logic [15:0] card_out_data;
  logic        rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fifo_level_dma i_fifo_level_dma (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .host_wr, .host_wdata,
    .host_rd, .host_rdata, .flag_clr_we, .flag_clr_mask, .xfer_active,
    .xfer_dir, .card_in_valid, .card_in_ready, .card_in_data,
    .card_out_valid, .card_out_ready, .card_out_data, .rx_dma_req,
    .tx_dma_req, .rx_lvl_flag, .tx_lvl_flag
  );

  function automatic logic [15:0] lvls();
    return {12'h000, rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic strobes_off();
    cfg_we = 1'b0; host_wr = 1'b0; host_rd = 1'b0; flag_clr_we = 1'b0;
    card_in_valid = 1'b0; card_out_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    strobes_off();
    xfer_active = 1'b0; xfer_dir = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_push(input logic [15:0] d);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [40:0] v;
    logic [2:0]  op;
    v  = VECS[idx];
    op = v[40:38];
    xfer_active = v[21];
    xfer_dir    = v[20];
    case (op)
      OP_CFG:  begin cfg_we = 1'b1; cfg_wdata = v[37:22]; end
      OP_HWR:  begin host_wr = 1'b1; host_wdata = v[37:22]; end
      OP_HRD:  host_rd = 1'b1;
      OP_CLR:  begin flag_clr_we = 1'b1; flag_clr_mask = v[37:22]; end
      OP_CPSH: begin card_in_valid = 1'b1; card_in_data = v[37:22]; end
      OP_CPOP: card_out_ready = 1'b1;
      default: ;
    endcase
    #1;
    if (op == OP_HRD) chk($sformatf("R1 R3 host read data vec %0d", idx), host_rdata, v[15:0]);
    if (op == OP_CPOP) begin
      chk($sformatf("R11 card_out_valid vec %0d", idx), {15'd0, card_out_valid}, 16'd1);
      chk($sformatf("R1 card_out_data vec %0d", idx), card_out_data, v[15:0]);
    end
    if (op == OP_CPSH)
      chk($sformatf("R11 card_in_ready vec %0d", idx), {15'd0, card_in_ready}, 16'd1);
    @(negedge clk);
    strobes_off();
    chk($sformatf("R5 R6 R7 R8 R9 R10 R12 levels vec %0d", idx), lvls(), {12'h000, v[19:16]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Reset state (R4, R8)
    do_reset();
    #1;
    chk("R4 reset config readback", cfg_rdata, 16'h1F00);
    chk("R8 reset levels", lvls(), 16'h0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    strobes_off();
    chk("R4 field mask readback", cfg_rdata, 16'h9F9F);
    chk("R8 idle empty after config", lvls(), 16'h0000);

    // Vector table
    for (int i = 0; i < NV; i++) run_vec(i);

    // Overflow and underflow (R1, R2, R3)
    do_reset();
    for (int i = 0; i < 32; i++) host_push(16'h1000 + 16'(i));
    host_push(16'hDEAD);
    for (int i = 0; i < 32; i++) begin
      #1;
      chk($sformatf("R1 R2 drain order %0d", i), host_rdata, 16'h1000 + 16'(i));
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
    end
    #1;
    chk("R3 empty read value", host_rdata, 16'h1000);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    #1;
    chk("R3 empty read kept head", host_rdata, 16'h1000);
    host_push(16'h5555);
    #1;
    chk("R3 index unchanged by empty read", host_rdata, 16'h5555);

    // Clear versus event in the same cycle (R10)
    do_reset();
    cfg_we = 1'b1; cfg_wdata = 16'h0000;
    xfer_active = 1'b1; xfer_dir = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    host_push(16'h1111);
    chk("R5 rx flag above level", lvls(), 16'h0002);
    host_wr = 1'b1; host_wdata = 16'h2222;
    flag_clr_we = 1'b1; flag_clr_mask = 16'h0400;
    @(negedge clk);
    strobes_off();
    chk("R10 event wins over clear", lvls(), 16'h0002);
    flag_clr_we = 1'b1; flag_clr_mask = 16'h0800;
    @(negedge clk);
    strobes_off();
    chk("R10 other bit leaves rx flag", lvls(), 16'h0002);
    flag_clr_we = 1'b1; flag_clr_mask = 16'h0400;
    @(negedge clk);
    strobes_off();
    chk("R10 clear alone", lvls(), 16'h0000);

    // Card handshake gating (R11)
    do_reset();
    #1;
    chk("R11 idle in_ready low", {15'd0, card_in_ready}, 16'd0);
    xfer_active = 1'b1; xfer_dir = 1'b1;
    #1;
    chk("R11 rx in_ready high", {15'd0, card_in_ready}, 16'd1);
    host_wr = 1'b1; host_wdata = 16'h7777;
    #1;
    chk("R11 host write blocks in_ready", {15'd0, card_in_ready}, 16'd0);
    @(negedge clk);
    host_wr = 1'b0;
    xfer_dir = 1'b0;
    #1;
    chk("R11 tx out_valid high", {15'd0, card_out_valid}, 16'd1);
    chk("R11 rx ready off in tx", {15'd0, card_in_ready}, 16'd0);
    host_rd = 1'b1;
    #1;
    chk("R11 host read blocks out_valid", {15'd0, card_out_valid}, 16'd0);
    @(negedge clk);
    host_rd = 1'b0;
    #1;
    chk("R11 out_valid low when empty", {15'd0, card_out_valid}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule